// File: doc/BRIEF.md
# Reset-Time Memory Configuration Loader

After reset this block works out the 36-bit word that sets up an external memory interface. It first runs a walking-low scan over 13 data lines while it watches one configuration input. A board that ties that input to one of the scanned lines picks the preset word for that line. The input falls in the scan step where the line is pulled low, and the block takes the first step in which it sees the input low.

If the input is already low before any line has been pulled low, the block enters external mode. In external mode it takes the word serially, one inverted bit per read cycle. The 36 read cycles run after every scan, in either mode, and no bus data is latched from them. Each read is offered to the memory side as a valid/ready transfer that carries an address.

Back-pressure on the read stream works as follows:
- `rd_valid` stays high, and `rd_addr` holds still, until `rd_ready` is sampled high.
- A transfer completes on each rising edge where both signals are high.
- In external mode, `cfg_in` is sampled on that same edge.

The final word appears together with `cfg_done` and is held until the next reset.

Top module: `cfg_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `scan_drive` is all ones and `rd_valid`, `cfg_done` and `cfg_word` are zero.
- R2: After reset, all lines stay high for HOLD_CLKS clocks and `cfg_in` is sampled at the end of that window. A low sample selects external mode.
- R3: Scan step k (k = 0..12) lasts HOLD_CLKS clocks. During step k, line positions 0..k are driven low and all other bits of `scan_drive` are high. Position p maps to bit p for p < 12, and position 12 maps to bit 31.
- R4: Outside external mode, if `cfg_in` is low at the last clock of step k, preset k is selected and the scan ends. `rd_valid` first reads high HOLD_CLKS*(k+2) clock edges after reset release.
- R5: If `cfg_in` stays high through all 13 steps, preset 12 (the slowest) is selected.
- R6: Preset k equals PRESET_BASE + k*PRESET_STRIDE, taken modulo 2^36.
- R7: After the scan there are exactly 36 read transfers. Transfer i uses address READ_BASE + 4*i, with a default first address of 0x7FFFFF6C. While `rd_ready` is low, `rd_valid` stays high and `rd_addr` is stable.
- R8: In external mode the scan ends after step 0. Bit i of the word (bit 0 first) is the inverse of `cfg_in` sampled at transfer i.
- R9: When a preset is selected, `cfg_in` during the reads has no effect on `cfg_word`.
- R10: `cfg_done` rises in the cycle after the 36th transfer, and `rd_valid` is low from then on. `cfg_word` reads zero before `cfg_done` and stays fixed after it until reset.
- R11: `rd_valid` is never high while any scan line is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in | input | 1 | Single-wire configuration input |
| scan_drive | output | 32 | Level driven onto the data lines during the scan |
| rd_valid | output | 1 | A configuration read is offered |
| rd_ready | input | 1 | The memory side accepts the read |
| rd_addr | output | 32 | Address of the offered read |
| cfg_word | output | 36 | Final configuration word, zero until done |
| cfg_done | output | 1 | Configuration is fixed |

## Verification
The scan timing is fully determined, so the bench counts falling edges from reset release and knows exactly which ones fall inside each step:
- Falling edges HOLD_CLKS*(k+1) through HOLD_CLKS*(k+2)-1 fall inside step k.
- `rd_valid` must first read high on falling edge HOLD_CLKS*(k+2).

A transfer completes on the rising edge that follows a falling edge where the bench drove `rd_ready` high. The bench therefore advances its expected address one falling edge later. At that same edge it expects `cfg_done` and the final word once the 36th transfer has been counted.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int unsigned CFG_W    = 36;
  localparam int unsigned LINE_W   = 32;
  localparam int unsigned N_PRESET = 13;

  typedef logic [CFG_W-1:0] cfg_word_t;
  typedef enum logic [1:0] {PH_PRE, PH_STEP, PH_FIN} scan_ph_t;

  // scan position -> data line bit
  function automatic logic [4:0] lane_of(input logic [3:0] pos);
    return (pos == 4'(N_PRESET - 1)) ? 5'd31 : {1'b0, pos};
  endfunction

  function automatic cfg_word_t preset_word(input cfg_word_t base, input cfg_word_t stride,
                                            input logic [3:0] k);
    return base + stride * cfg_word_t'(k);
  endfunction
endpackage

// File: rtl/cfgld_scan.sv
module cfgld_scan
  import cfgld_pkg::*;
#(
  parameter int HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_in,
  output logic [LINE_W-1:0] drive,
  output logic              fin,
  output logic              ext,
  output logic [3:0]        sel
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [3:0] LAST = 4'(N_PRESET - 1);

  scan_ph_t      ph;
  logic [CW-1:0] cnt;
  logic [3:0]    step;
  logic          hold_end;
  logic [N_PRESET-1:0] low_mask;

  assign hold_end = (cnt == CW'(HOLD - 1));
  assign fin      = (ph == PH_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_PRE;
      cnt  <= '0;
      step <= '0;
      ext  <= 1'b0;
      sel  <= LAST;
    end else begin
      unique case (ph)
        PH_PRE: begin
          if (hold_end) begin
            cnt <= '0;
            ext <= ~cfg_in;
            ph  <= PH_STEP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_STEP: begin
          if (hold_end) begin
            cnt <= '0;
            if (ext) begin
              ph <= PH_FIN;
            end else if (!cfg_in) begin
              sel <= step;
              ph  <= PH_FIN;
            end else if (step == LAST) begin
              ph <= PH_FIN;
            end else begin
              step <= step + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_PRESET; g++) begin : g_mask
    assign low_mask[g] = (ph == PH_STEP) && (step >= 4'(g));
  end

  always_comb begin
    drive = '1;
    for (int j = 0; j < N_PRESET; j++)
      if (low_mask[j]) drive[lane_of(4'(j))] = 1'b0;
  end
endmodule

// File: rtl/cfgld_reads.sv
module cfgld_reads
  import cfgld_pkg::*;
#(
  parameter int          NRD  = 36,
  parameter logic [31:0] BASE = 32'h7FFF_FF6C
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           ext,
  input  logic           cfg_in,
  input  logic           rd_ready,
  output logic           rd_valid,
  output logic [31:0]    rd_addr,
  output logic [NRD-1:0] cap,
  output logic           done
);
  localparam int IW = $clog2(NRD);

  logic [IW-1:0] idx;
  logic          hs;

  assign rd_valid = go && !done;
  assign hs       = rd_valid && rd_ready;
  assign rd_addr  = BASE + 32'({idx, 2'b00});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      done <= 1'b0;
      cap  <= '0;
    end else if (hs) begin
      if (ext) cap[idx] <= ~cfg_in;
      if (idx == IW'(NRD - 1)) done <= 1'b1;
      else                     idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgld_pkg::*;
#(
  parameter int          HOLD_CLKS     = 4,
  parameter logic [31:0] READ_BASE     = 32'h7FFF_FF6C,
  parameter logic [35:0] PRESET_BASE   = 36'h1_2345_6780,
  parameter logic [35:0] PRESET_STRIDE = 36'h0_0F0E_0D0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_in,
  output logic [LINE_W-1:0] scan_drive,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [31:0]       rd_addr,
  output logic [CFG_W-1:0]  cfg_word,
  output logic              cfg_done
);
  logic       fin, ext;
  logic [3:0] sel;
  cfg_word_t  cap;
  cfg_word_t  ptab [N_PRESET];

  cfgld_scan #(.HOLD(HOLD_CLKS)) u_scan (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in),
    .drive(scan_drive), .fin(fin), .ext(ext), .sel(sel)
  );

  cfgld_reads #(.NRD(CFG_W), .BASE(READ_BASE)) u_reads (
    .clk(clk), .rst_n(rst_n), .go(fin), .ext(ext), .cfg_in(cfg_in),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .cap(cap), .done(cfg_done)
  );

  for (genvar g = 0; g < N_PRESET; g++) begin : g_preset
    assign ptab[g] = preset_word(PRESET_BASE, PRESET_STRIDE, 4'(g));
  end

  assign cfg_word = !cfg_done ? '0 : (ext ? cap : ptab[sel]);
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter logic [31:0] READ_BASE = 32'h7FFF_FF6C
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] scan_drive,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_addr,
  input logic [35:0] cfg_word,
  input logic        cfg_done
);
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> !rd_valid || (rd_addr == $past(rd_addr) + 32'd4)); // R7
  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> rd_addr == READ_BASE); // R7
  AST_DONE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done && $stable(cfg_word)); // R10
  AST_WORD_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> cfg_word == '0); // R10
  AST_NO_READ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !rd_valid); // R10
  AST_NO_READ_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_drive != '1) |-> !rd_valid); // R11
  AST_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_drive != $past(scan_drive)) |->
      (scan_drive == '1) || ($countones(~scan_drive) == $countones(~$past(scan_drive)) + 1)); // R3
endmodule

bind cfg_loader cfg_loader_chk #(.READ_BASE(READ_BASE)) i_chk (.*);

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
  localparam int          HOLD   = 4;
  localparam logic [31:0] RBASE  = 32'h7FFF_FF6C;
  localparam logic [35:0] PBASE  = 36'h1_2345_6780;
  localparam logic [35:0] PSTEP  = 36'h0_0F0E_0D0C;
  localparam int          NREADS = 36;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_ready = 1'b0;
  logic        cfg_force = 1'b1;
  logic        tie_on = 1'b0;
  int          tie_k = 0;
  logic        cfg_in;
  logic [31:0] scan_drive, rd_addr;
  logic        rd_valid, cfg_done;
  logic [35:0] cfg_word;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  function automatic int lane(input int p);
    return (p == 12) ? 31 : p;
  endfunction

  assign cfg_in = tie_on ? scan_drive[lane(tie_k)] : cfg_force;

  cfg_loader i_cfg_loader (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .scan_drive(scan_drive),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .cfg_word(cfg_word), .cfg_done(cfg_done)
  );

  function automatic logic [31:0] exp_drive(input int j);
    logic [31:0] d = '1;
    for (int i = 0; i <= j; i++) d[lane(i)] = 1'b0;
    return d;
  endfunction

  function automatic logic [35:0] exp_preset(input int k);
    return PBASE + PSTEP * 36'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // k >= 0 ties cfg_in to scan position k; k < 0 leaves it high
  task automatic run_case(input int k, input bit ext, input logic [35:0] w);
    int          m_fin, cnt;
    bit          prev_hs;
    logic [35:0] exp_w, held;
    rst_n = 1'b0; rd_ready = 1'b0;
    tie_k = (k >= 0) ? k : 0;
    tie_on = (k >= 0) && !ext;
    cfg_force = ext ? 1'b0 : 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(scan_drive == '1 && !rd_valid && !cfg_done && cfg_word == '0, "R1 reset",
        {rd_valid, cfg_done, scan_drive}, {2'b00, 32'hFFFF_FFFF});
    rst_n = 1'b1;
    m_fin = ext ? 2*HOLD : (k >= 0 ? HOLD*(k+2) : HOLD*14);
    for (int m = 1; m <= m_fin; m++) begin
      logic [31:0] ed;
      @(negedge clk);
      if (m == 1)
        chk(scan_drive == '1 && !rd_valid && !cfg_done && cfg_word == '0, "R1 after release",
            scan_drive, 32'hFFFF_FFFF);
      ed = (m >= HOLD && m < m_fin) ? exp_drive(m/HOLD - 1) : '1;
      chk(scan_drive == ed, ext ? "R2 R3 scan drive" : "R3 scan drive", scan_drive, ed);
      chk(rd_valid == (m == m_fin), k < 0 && !ext ? "R5 R11 read start" : (ext ? "R8 R11 read start" : "R4 R11 read start"),
          rd_valid, (m == m_fin));
    end
    tie_on = 1'b0;
    exp_w = ext ? ~w : exp_preset(k >= 0 ? k : 12);
    cnt = 0; prev_hs = 1'b0;
    for (int guard = 0; guard < 2000; guard++) begin
      if (prev_hs) cnt++;
      if (cnt == NREADS) break;
      chk(rd_valid && rd_addr == RBASE + 32'(4*cnt), "R7 read addr", rd_addr, RBASE + 32'(4*cnt));
      chk(!cfg_done && cfg_word == '0, "R10 not yet done", {cfg_done, cfg_word}, 0);
      rd_ready = ($urandom % 4) != 0;
      cfg_force = ext ? w[cnt] : 1'($urandom);
      prev_hs = rd_ready;
      @(negedge clk);
    end
    rd_ready = 1'b0;
    chk(cnt == NREADS && cfg_done && !rd_valid, "R10 done after 36", {cnt[7:0], cfg_done, rd_valid}, {8'd36, 2'b10});
    chk(cfg_word == exp_w, ext ? "R8 external word" : (k < 0 ? "R5 R6 R9 slowest preset" : "R6 R9 preset word"),
        cfg_word, exp_w);
    held = cfg_word;
    repeat (5) begin
      cfg_force = 1'($urandom); rd_ready = 1'($urandom);
      @(negedge clk);
    end
    chk(cfg_word == held && cfg_done && !rd_valid, "R10 R9 word held", cfg_word, held);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 13; k++) run_case(k, 1'b0, '0);   // R4 each line, R5 via k=12
    run_case(-1, 1'b0, '0);                                // R5 no response
    run_case(-1, 1'b1, 36'h0_0000_0000);                   // R8 corner
    run_case(-1, 1'b1, 36'hF_FFFF_FFFF);                   // R8 corner
    run_case(-1, 1'b1, 36'h8_0000_0001);                   // R8 end bits
    for (int r = 0; r < 4; r++) run_case(-1, 1'b1, {4'($urandom), 32'($urandom)}); // R8 random
    for (int r = 0; r < 3; r++) run_case(int'($urandom % 13), 1'b0, '0);          // R4 random
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule